// File: doc/BRIEF.md
# DMA Request Handshake

This block pairs the two ends of a single-cycle DMA handshake on an expansion bus. On the expansion-module side, a pending-transfer counter is loaded with work. While work remains, the side raises an active-high request. It drops that request one clock after it sees the acknowledge, which keeps the host from treating the exchange as a burst. When the command of its last transfer begins, it raises a terminate pulse. It can also hold a wait line low to stretch a command, which makes the data phase interlocked rather than full-speed.

On the host side, an acknowledge sequencer waits for its local-bus grant and a fresh request. It then drives the active-low acknowledge, holds off the I/O command by a minimum delay, and keeps the acknowledge low for a minimum time after the command ends. The sequencer samples the request once at the end of a removal window. A request still high at that point marks the exchange as a burst, and further commands follow under the same acknowledge. All intervals are given in nanoseconds and converted to clock cycles from a clock-period parameter. The two halves are wired together at the top so that they can be exercised as a pair. The data transfer itself is not part of the block.

Top module: `dma_handshake_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dreq`=0, `dack_n`=1, `iocmd_n`=1, `wait_n`=1, `tdma`=0, `host_burst`=0.
- R2: The module raises `dreq` only when its pending count is nonzero and, on the cycle before, both `dack_n` and `iocmd_n` were high. A `load_valid` cycle adds `load_count` to the count, saturating. With an empty count, `dreq` stays 0.
- R3: `dack_n` falls only on an edge where `bus_grant` and `dreq` are high, and only once `dreq` has been seen low since the previous acknowledge. With `bus_grant` low, `dack_n` stays 1.
- R4: The first `iocmd_n` fall under an acknowledge comes exactly ceil(25 ns / period) cycles after `dack_n` falls (2 cycles at 20 ns).
- R5: With `burst_req`=0 latched at request time, `dreq` falls exactly one cycle after `dack_n` falls.
- R6: The host samples `dreq` at the floor(150 ns / period)-th edge after the acknowledge and copies it to `host_burst`. With `host_burst`=1 and `dreq` still high at the end of a hold, the next command starts HOLD+SETUP cycles after the previous `iocmd_n` rise, under the same acknowledge. With `burst_req`=1, the module keeps `dreq` high until the command of its last pending transfer starts, so one acknowledge carries all pending transfers.
- R7: `dack_n` rises exactly ceil(25 ns / period) cycles after `iocmd_n` rises (2 cycles at 20 ns).
- R8: `iocmd_n` stays low for ceil(300 ns / period) cycles (15), and is not released while `wait_n` is low. With `slow_xfer`=1 it stays low for WAIT_CYC+2 cycles (22 at default).
- R9: With `slow_xfer`=1, `wait_n` falls one cycle after `iocmd_n` falls and stays low for WAIT_CYC cycles (20). With `slow_xfer`=0, `wait_n` stays high.
- R10: `tdma` rises one cycle after the command of the final pending transfer falls, stays high for ceil(300 ns / period) cycles (15), and occurs once per drained batch.
- R11: Each completed command (an `iocmd_n` rise under acknowledge) lowers the pending count by one. The number of commands equals the total loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Adds `load_count` to the pending count this cycle |
| load_count | input | CNT_W | Number of transfers to add |
| burst_req | input | 1 | Module keeps its request through all pending transfers |
| slow_xfer | input | 1 | Module stretches each command with its wait line |
| bus_grant | input | 1 | Host local bus granted to the DMA controller |
| dreq | output | 1 | Active-high transfer request from the module |
| dack_n | output | 1 | Active-low acknowledge from the host |
| iocmd_n | output | 1 | Active-low I/O command from the host |
| wait_n | output | 1 | Active-low wait from the module |
| tdma | output | 1 | Terminate pulse from the module on the final transfer |
| host_burst | output | 1 | Host classified the current exchange as a burst |

## Verification
The assertions assume that `burst_req` and `slow_xfer` stay constant while a batch drains. They also assume that work is loaded only while the pair is idle, and that the default timing satisfies two orderings: the removal window closes before the first command ends, and the wait pulse ends while the command is active. The stimulus changes the mode inputs and loads a batch only after the previous batch has fully drained. It holds `bus_grant` low only in a dedicated phase in which no acknowledge may appear.

// File: rtl/dmahs_pkg.sv
`timescale 1ns/1ps
package dmahs_pkg;

    function automatic int ceil_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int floor_cyc(input int ns, input int period);
        int c;
        c = ns / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    typedef enum logic [1:0] {
        H_IDLE,
        H_SETUP,
        H_CMD,
        H_HOLD
    } host_st_e;

    typedef enum logic [1:0] {
        D_IDLE,
        D_REQ,
        D_XFER
    } dev_st_e;

    typedef struct packed {
        logic dack_n;
        logic iocmd_n;
    } host_bus_t;

endpackage

// File: rtl/dmahs_pulse.sv
`timescale 1ns/1ps
module dmahs_pulse #(
    parameter int LEN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int W = $clog2(LEN + 1);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= LAST;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end
endmodule

// File: rtl/dmahs_host_ack.sv
`timescale 1ns/1ps
module dmahs_host_ack
    import dmahs_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int CMD_CYC   = 15,
    parameter int HOLD_CYC  = 2,
    parameter int DROP_CYC  = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic dreq,
    input  logic bus_grant,
    input  logic wait_n,
    output logic dack_n,
    output logic iocmd_n,
    output logic host_burst
);
    localparam int CW = $clog2(max3(SETUP_CYC, CMD_CYC, HOLD_CYC) + 1);
    localparam int AW = $clog2(DROP_CYC + 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] CMD_LAST   = CW'(CMD_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [AW-1:0] AGE_END    = AW'(DROP_CYC);
    localparam logic [AW-1:0] AGE_SAMPLE = AW'(DROP_CYC - 1);

    host_st_e  st;
    host_bus_t bus;
    logic [CW-1:0] cnt;
    logic [AW-1:0] age;
    logic armed;
    logic issue;

    assign dack_n  = bus.dack_n;
    assign iocmd_n = bus.iocmd_n;
    assign issue   = (st == H_IDLE) && dreq && armed && bus_grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= H_IDLE;
            bus.dack_n  <= 1'b1;
            bus.iocmd_n <= 1'b1;
            cnt         <= '0;
            age         <= '0;
            armed       <= 1'b0;
            host_burst  <= 1'b0;
        end else begin
            // rearm only after the request has been seen low
            if (issue) begin
                armed <= 1'b0;
            end else if (!dreq) begin
                armed <= 1'b1;
            end
            // removal window: one sample of the request decides burst
            if (st != H_IDLE && age != AGE_END) begin
                age <= age + AW'(1);
                if (age == AGE_SAMPLE) begin
                    host_burst <= dreq;
                end
            end
            case (st)
                H_IDLE: begin
                    if (issue) begin
                        bus.dack_n <= 1'b0;
                        st         <= H_SETUP;
                        cnt        <= '0;
                        age        <= '0;
                        host_burst <= 1'b0;
                    end
                end
                H_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        bus.iocmd_n <= 1'b0;
                        st          <= H_CMD;
                        cnt         <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                H_CMD: begin
                    if (cnt >= CMD_LAST && wait_n) begin
                        bus.iocmd_n <= 1'b1;
                        st          <= H_HOLD;
                        cnt         <= '0;
                    end else if (cnt < CMD_LAST) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                H_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        cnt <= '0;
                        if (host_burst && dreq) begin
                            st <= H_SETUP;
                        end else begin
                            bus.dack_n <= 1'b1;
                            st         <= H_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= H_IDLE;
            endcase
        end
    end

    // R3: acknowledge only on a granted, fresh request
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dack_n) |-> ($past(dreq) && $past(bus_grant) && $past(armed)));

    // R4: the command never runs outside the acknowledge
    p_cmd_inside_ack_r4: assert property (@(posedge clk) disable iff (rst)
        !iocmd_n |-> !dack_n);

    // R7: the acknowledge outlives the command
    p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(iocmd_n) |-> !dack_n);

    // R8: a low wait keeps the command active
    p_wait_extends_r8: assert property (@(posedge clk) disable iff (rst)
        (!iocmd_n && !wait_n) |=> !iocmd_n);

endmodule

// File: rtl/dmahs_dev_req.sv
`timescale 1ns/1ps
module dmahs_dev_req
    import dmahs_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WAIT_CYC = 20,
    parameter int TERM_CYC = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    input  logic [CNT_W-1:0] load_count,
    input  logic             burst_req,
    input  logic             slow_xfer,
    input  logic             dack_n,
    input  logic             iocmd_n,
    output logic             dreq,
    output logic             wait_n,
    output logic             tdma
);
    dev_st_e st;
    logic [CNT_W-1:0] pending;
    logic [CNT_W-1:0] pend_nxt;
    logic [CNT_W:0]   sum;
    logic bmode;
    logic cmd_q;
    logic cmd_fall, cmd_rise;
    logic in_xfer, done, last;
    logic wait_start, term_start, wait_act;

    assign cmd_fall   = cmd_q & ~iocmd_n;
    assign cmd_rise   = ~cmd_q & iocmd_n;
    assign in_xfer    = (st == D_XFER);
    assign done       = in_xfer & cmd_rise;
    assign last       = (pending == CNT_W'(1));
    assign wait_start = in_xfer & cmd_fall & slow_xfer;
    assign term_start = in_xfer & cmd_fall & last;
    assign wait_n     = ~wait_act;

    always_comb begin
        sum = {1'b0, pending} + (load_valid ? {1'b0, load_count} : (CNT_W+1)'(0));
        if (done && sum != '0) begin
            sum = sum - (CNT_W+1)'(1);
        end
        pend_nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= D_IDLE;
            pending <= '0;
            bmode   <= 1'b0;
            cmd_q   <= 1'b1;
            dreq    <= 1'b0;
        end else begin
            cmd_q   <= iocmd_n;
            pending <= pend_nxt;
            case (st)
                D_IDLE: begin
                    if (pending != '0 && dack_n && iocmd_n) begin
                        dreq  <= 1'b1;
                        bmode <= burst_req;
                        st    <= D_REQ;
                    end
                end
                D_REQ: begin
                    if (!dack_n) begin
                        st <= D_XFER;
                        if (!bmode) begin
                            dreq <= 1'b0;
                        end
                    end
                end
                D_XFER: begin
                    if (cmd_fall && last && bmode) begin
                        dreq <= 1'b0;
                    end
                    if (dack_n && iocmd_n) begin
                        dreq <= 1'b0;
                        st   <= D_IDLE;
                    end
                end
                default: st <= D_IDLE;
            endcase
        end
    end

    dmahs_pulse #(.LEN(WAIT_CYC)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .start  (wait_start),
        .active (wait_act)
    );

    dmahs_pulse #(.LEN(TERM_CYC)) u_term (
        .clk    (clk),
        .rst    (rst),
        .start  (term_start),
        .active (tdma)
    );

    // R2: nothing to move means no request
    p_idle_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (st == D_IDLE && pending == '0) |-> !dreq);

    // R5: single-cycle mode withdraws the request right after the acknowledge
    p_single_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(dack_n) && !bmode) |=> !dreq);

    // R9: wait is held only inside a command
    p_wait_in_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> !iocmd_n);

    // R10: terminate starts while the final command runs
    p_term_in_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tdma) |-> !iocmd_n);

endmodule

// File: rtl/dma_handshake_top.sv
`timescale 1ns/1ps
module dma_handshake_top
    import dmahs_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SETUP_NS      = 25,
    parameter int DROP_NS       = 150,
    parameter int HOLD_NS       = 25,
    parameter int CMD_NS        = 300,
    parameter int TERM_NS       = 300,
    parameter int WAIT_CYC      = 20,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    input  logic [CNT_W-1:0] load_count,
    input  logic             burst_req,
    input  logic             slow_xfer,
    input  logic             bus_grant,
    output logic             dreq,
    output logic             dack_n,
    output logic             iocmd_n,
    output logic             wait_n,
    output logic             tdma,
    output logic             host_burst
);
    localparam int SETUP_CYC = ceil_cyc(SETUP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC  = ceil_cyc(HOLD_NS, CLK_PERIOD_NS);
    localparam int CMD_CYC   = ceil_cyc(CMD_NS, CLK_PERIOD_NS);
    localparam int TERM_CYC  = ceil_cyc(TERM_NS, CLK_PERIOD_NS);
    localparam int DROP_CYC  = floor_cyc(DROP_NS, CLK_PERIOD_NS);

    dmahs_dev_req #(
        .CNT_W    (CNT_W),
        .WAIT_CYC (WAIT_CYC),
        .TERM_CYC (TERM_CYC)
    ) u_dev (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_count (load_count),
        .burst_req  (burst_req),
        .slow_xfer  (slow_xfer),
        .dack_n     (dack_n),
        .iocmd_n    (iocmd_n),
        .dreq       (dreq),
        .wait_n     (wait_n),
        .tdma       (tdma)
    );

    dmahs_host_ack #(
        .SETUP_CYC (SETUP_CYC),
        .CMD_CYC   (CMD_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .DROP_CYC  (DROP_CYC)
    ) u_host (
        .clk        (clk),
        .rst        (rst),
        .dreq       (dreq),
        .bus_grant  (bus_grant),
        .wait_n     (wait_n),
        .dack_n     (dack_n),
        .iocmd_n    (iocmd_n),
        .host_burst (host_burst)
    );
endmodule

// File: tb/dma_handshake_top_tb.sv
`timescale 1ns/1ps
module dma_handshake_top_tb;
    localparam int SETUP    = 2;
    localparam int HOLD     = 2;
    localparam int CMD      = 15;
    localparam int WAITC    = 20;
    localparam int TERM     = 15;
    localparam int SLOW_LEN = WAITC + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_valid = 1'b0;
    logic [7:0] load_count = '0;
    logic burst_req = 1'b0;
    logic slow_xfer = 1'b0;
    logic bus_grant = 1'b0;
    logic dreq, dack_n, iocmd_n, wait_n, tdma, host_burst;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // stimulus-owned
    int loaded_total = 0;
    // monitor-owned
    int t = 0;
    int done_total = 0;
    int cmds_total = 0;
    int tdma_total = 0;
    logic pdack = 1'b1, pcmd = 1'b1, pdreq = 1'b0, pwait = 1'b1, ptdma = 1'b0;
    int ack_t = 0, cmd_f_t = 0, cmd_r_t = 0, wait_f_t = 0, tdma_r_t = 0;
    bit first_in_ack = 0;
    int cmds_in_ack = 0;
    int pend_at_ack = 0;

    always #10 clk = ~clk;

    dma_handshake_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_count (load_count),
        .burst_req  (burst_req),
        .slow_xfer  (slow_xfer),
        .bus_grant  (bus_grant),
        .dreq       (dreq),
        .dack_n     (dack_n),
        .iocmd_n    (iocmd_n),
        .wait_n     (wait_n),
        .tdma       (tdma),
        .host_burst (host_burst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0d)", req, act, exp, t);
        end
    endtask

    // reference monitor: evaluated once per clock, half a period after the edge
    always @(negedge clk) begin
        if (!rst) begin
            t++;
            if (pdack && !dack_n) begin
                chk(bus_grant && pdreq, "R3 ack on granted request", int'(bus_grant && pdreq), 1);
                ack_t = t;
                first_in_ack = 1;
                cmds_in_ack = 0;
                pend_at_ack = loaded_total - done_total;
            end
            if (pdreq && !dreq && !burst_req)
                chk(t - ack_t == 1, "R5 request drop delay", t - ack_t, 1);
            if (!pdreq && dreq)
                chk(pdack && pcmd && (loaded_total > done_total), "R2 request conditions",
                    loaded_total - done_total, 1);
            if (pcmd && !iocmd_n) begin
                if (first_in_ack)
                    chk(t - ack_t == SETUP, "R4 ack to command", t - ack_t, SETUP);
                else
                    chk(t - cmd_r_t == HOLD + SETUP, "R6 burst command gap", t - cmd_r_t, HOLD + SETUP);
                first_in_ack = 0;
                cmd_f_t = t;
                cmds_in_ack++;
                cmds_total++;
            end
            if (!pcmd && iocmd_n) begin
                chk(t - cmd_f_t == (slow_xfer ? SLOW_LEN : CMD), "R8 command length",
                    t - cmd_f_t, slow_xfer ? SLOW_LEN : CMD);
                cmd_r_t = t;
                done_total++;
            end
            if (!pdack && dack_n) begin
                chk(t - cmd_r_t == HOLD, "R7 ack hold", t - cmd_r_t, HOLD);
                chk(cmds_in_ack == (burst_req ? pend_at_ack : 1), "R6 commands per ack",
                    cmds_in_ack, burst_req ? pend_at_ack : 1);
                chk(host_burst == (burst_req && pend_at_ack >= 2), "R6 burst flag",
                    int'(host_burst), int'(burst_req && pend_at_ack >= 2));
            end
            if (pwait && !wait_n) begin
                chk(slow_xfer && (t - cmd_f_t == 1), "R9 wait start", t - cmd_f_t, 1);
                wait_f_t = t;
            end
            if (!pwait && wait_n)
                chk(t - wait_f_t == WAITC, "R9 wait length", t - wait_f_t, WAITC);
            if (!ptdma && tdma) begin
                chk((t - cmd_f_t == 1) && (loaded_total - done_total == 1), "R10 terminate start",
                    t - cmd_f_t, 1);
                tdma_r_t = t;
                tdma_total++;
            end
            if (ptdma && !tdma)
                chk(t - tdma_r_t == TERM, "R10 terminate length", t - tdma_r_t, TERM);
            pdack = dack_n;
            pcmd  = iocmd_n;
            pdreq = dreq;
            pwait = wait_n;
            ptdma = tdma;
        end
    end

    task automatic load(input int n);
        @(negedge clk);
        #2;
        load_valid = 1'b1;
        load_count = 8'(n);
        loaded_total += n;
        @(negedge clk);
        #2;
        load_valid = 1'b0;
        load_count = '0;
    endtask

    task automatic drain(input int n, input int cmd_base, input int tdma_base);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            #3;
            if (loaded_total == done_total && dack_n && iocmd_n && !tdma && !dreq) break;
        end
        repeat (5) @(negedge clk);
        #3;
        chk(cmds_total - cmd_base == n, "R11 commands per batch", cmds_total - cmd_base, n);
        chk(tdma_total - tdma_base == 1, "R10 terminate once", tdma_total - tdma_base, 1);
        chk(dreq == 1'b0, "R2 no request when empty", int'(dreq), 0);
    endtask

    task automatic run(input int n, input bit burst, input bit slow);
        int cb;
        int tb;
        @(negedge clk);
        #2;
        burst_req = burst;
        slow_xfer = slow;
        cb = cmds_total;
        tb = tdma_total;
        load(n);
        drain(n, cb, tb);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cb;
        int tb;
        repeat (3) @(negedge clk);
        #3;
        // R1 during reset
        chk(dreq == 1'b0 && dack_n && iocmd_n && wait_n && !tdma && !host_burst,
            "R1 reset outputs", int'({dreq, dack_n, iocmd_n, wait_n, tdma, host_burst}), 6'b011100);
        @(negedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        #3;
        chk(dreq == 1'b0 && dack_n && iocmd_n && wait_n && !tdma && !host_burst,
            "R1 after reset", int'({dreq, dack_n, iocmd_n, wait_n, tdma, host_burst}), 6'b011100);

        // R3: no grant, no acknowledge; R2: request still raised
        cb = cmds_total;
        tb = tdma_total;
        load(1);
        repeat (30) @(negedge clk);
        #3;
        chk(dack_n == 1'b1, "R3 ack held off without grant", int'(dack_n), 1);
        chk(dreq == 1'b1, "R2 request with pending work", int'(dreq), 1);
        bus_grant = 1'b1;
        drain(1, cb, tb);

        run(3, 1'b0, 1'b0);   // single-cycle, full speed
        run(2, 1'b0, 1'b1);   // single-cycle, interlocked
        run(3, 1'b1, 1'b0);   // burst, full speed
        run(1, 1'b1, 1'b1);   // burst request with a single transfer
        run(2, 1'b1, 1'b0);   // short burst
        run(1, 1'b0, 1'b0);   // lone single transfer

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule